// File: doc/BRIEF.md
# Status-Flag Arithmetic/Logic Unit

This block is the integer execution slice of a small processor datapath. It takes two operands, an operation code, a byte/word width select and a valid strobe. In the same cycle it produces a result and a write-enable for the destination register. It keeps a six-bit status register that is loaded on the clock edge of each valid operation whose rules call for a flag update. The supported operations are:

- add, subtract and compare
- AND, OR, XOR and test
- bitwise complement
- a move that passes the source through

Every result and every flag is computed at the selected width. Byte operations use the low 8 bits of each operand and return zeros in the upper half of the result. Word operations use all 16 bits. The exceptions are parity, which always looks at the low byte only, and auxiliary carry, which always comes from the carry or borrow across bit 3 to bit 4.

Operand A is the destination operand and operand B is the source operand. Subtraction and compare compute A minus B. The status register presents carry on bit 0, parity on bit 1, auxiliary carry on bit 2, zero on bit 3, sign on bit 4 and overflow on bit 5.

Top module: `flag_alu`

## Requirements
- R1: With the width select low, the operation uses only the low 8 bits of each operand, the result's bits 15:8 are zero, and carry, sign and overflow are taken at bit 7. With the width select high, all 16 bits are used and these flags are taken at bit 15.
- R2: Opcode 0 (add) returns A+B truncated to the width, asserts the write-enable, and sets carry to the carry-out of the selected width.
- R3: Opcode 1 (subtract) returns A−B truncated to the width, asserts the write-enable, and sets carry to 1 exactly when A is unsigned-less than B.
- R4: For add, subtract and compare, overflow is 1 exactly when the signed result falls outside the signed range of the selected width.
- R5: For add, subtract and compare, auxiliary carry is the carry or borrow out of bit 3 into bit 4.
- R6: For every flag-updating operation, parity is 1 when bits 7:0 of the result hold an even number of ones, and 0 otherwise. This holds also for word operations.
- R7: For every flag-updating operation, zero is 1 exactly when the width-truncated result is zero, and sign equals the top bit of the result at the selected width.
- R8: Opcode 8 (move) returns B at the selected width, asserts the write-enable, and leaves all six flags unchanged.
- R9: Opcode 2 (compare) updates the flags exactly as subtract does. Opcode 6 (test) updates the flags exactly as AND does. Both keep the write-enable low while the result port shows the difference or the AND value.
- R10: Opcodes 3, 4 and 5 (AND, OR, XOR) return the bitwise result and assert the write-enable. They clear carry, overflow and auxiliary carry, and set zero, sign and parity from the result.
- R11: Opcode 7 (complement) returns the bitwise inverse of A at the selected width, asserts the write-enable, and leaves the flags unchanged.
- R12: The flags reset to all zeros. They change only on a clock edge with valid high. When valid is low, the write-enable is 0. Opcodes 9 to 15 return a zero result, never assert the write-enable, and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation strobe |
| opCode | input | 4 | Operation select |
| isWord | input | 1 | 1 = 16-bit, 0 = 8-bit |
| srcA | input | 16 | Destination operand A |
| srcB | input | 16 | Source operand B |
| result | output | 16 | Result, zero-extended for byte ops |
| destWe | output | 1 | Destination write-enable |
| flags | output | 6 | {overflow, sign, zero, aux, parity, carry} |

## Verification
The bench builds the block with its defaults: a 16-bit word, an 8-bit byte and a bit-4 nibble boundary. This lets every operation run at both widths. It exercises wrap-around at 0xFF and 0xFFFF and signed overflow at both 0x7F/0x80 and 0x7FFF/0x8000. It also covers a word result whose low byte is zero while the whole word is not zero, which separates low-byte parity from the zero flag. Flags are preloaded with known nonzero values before each move, complement, idle cycle and reserved opcode, so that any change to them is visible at the port.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_TEST = 4'd6,
    OP_NOT  = 4'd7,
    OP_MOV  = 4'd8
  } aluOp_e;

  typedef enum logic [2:0] {
    RS_ADD,
    RS_SUB,
    RS_AND,
    RS_OR,
    RS_XOR,
    RS_NOT,
    RS_MOV,
    RS_ZERO
  } resSel_e;

  typedef enum logic [1:0] {
    FK_ARITH_ADD,
    FK_ARITH_SUB,
    FK_LOGIC
  } flagKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    resSel_e   resSel;
    flagKind_e flagKind;
    logic      writeDest;
    logic      loadFlags;
  } aluCtrl_t;

  // Bit 0 is carry, bit 5 is overflow
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } aluFlags_t;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic             inValid,
  input  logic [OPC_W-1:0] opCode,
  output aluCtrl_t         ctrl
);

  always_comb begin
    ctrl.resSel    = RS_ZERO;
    ctrl.flagKind  = FK_LOGIC;
    ctrl.writeDest = 1'b0;
    ctrl.loadFlags = 1'b0;
    case (opCode)
      OP_ADD: begin
        ctrl.resSel    = RS_ADD;
        ctrl.flagKind  = FK_ARITH_ADD;
        ctrl.writeDest = inValid;
        ctrl.loadFlags = inValid;
      end
      OP_SUB: begin
        ctrl.resSel    = RS_SUB;
        ctrl.flagKind  = FK_ARITH_SUB;
        ctrl.writeDest = inValid;
        ctrl.loadFlags = inValid;
      end
      OP_CMP: begin
        ctrl.resSel    = RS_SUB;
        ctrl.flagKind  = FK_ARITH_SUB;
        ctrl.loadFlags = inValid;
      end
      OP_AND: begin
        ctrl.resSel    = RS_AND;
        ctrl.writeDest = inValid;
        ctrl.loadFlags = inValid;
      end
      OP_OR: begin
        ctrl.resSel    = RS_OR;
        ctrl.writeDest = inValid;
        ctrl.loadFlags = inValid;
      end
      OP_XOR: begin
        ctrl.resSel    = RS_XOR;
        ctrl.writeDest = inValid;
        ctrl.loadFlags = inValid;
      end
      OP_TEST: begin
        ctrl.resSel    = RS_AND;
        ctrl.loadFlags = inValid;
      end
      OP_NOT: begin
        ctrl.resSel    = RS_NOT;
        ctrl.writeDest = inValid;
      end
      OP_MOV: begin
        ctrl.resSel    = RS_MOV;
        ctrl.writeDest = inValid;
      end
      default: begin
        ctrl.resSel = RS_ZERO;
      end
    endcase
  end

endmodule

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  aluCtrl_t          ctrl,
  input  logic              isWord,
  input  logic [WORD_W-1:0] srcA,
  input  logic [WORD_W-1:0] srcB,
  output logic [WORD_W-1:0] result,
  output logic              carryOut,
  output logic              msbA,
  output logic              msbB,
  output logic [WORD_W-1:0] opA,
  output logic [WORD_W-1:0] opB
);

  localparam int SUM_W = WORD_W + 1;
  localparam int HI_W  = WORD_W - BYTE_W;

  logic [WORD_W-1:0] widthMask;
  logic [SUM_W-1:0]  sumX;
  logic [SUM_W-1:0]  diffX;
  logic [SUM_W-1:0]  arithX;
  logic [WORD_W-1:0] rawRes;

  generate
    if (HI_W > 0) begin : g_split
      assign widthMask = isWord ? {WORD_W{1'b1}} : {{HI_W{1'b0}}, {BYTE_W{1'b1}}};
    end else begin : g_flat
      assign widthMask = {WORD_W{1'b1}};
    end
  endgenerate

  assign opA = srcA & widthMask;
  assign opB = srcB & widthMask;

  assign sumX   = {1'b0, opA} + {1'b0, opB};
  assign diffX  = {1'b0, opA} - {1'b0, opB};
  assign arithX = (ctrl.resSel == RS_SUB) ? diffX : sumX;

  // For byte ops the upper operand bits are zero, so bit BYTE_W is the carry or borrow
  assign carryOut = isWord ? arithX[WORD_W] : arithX[BYTE_W];

  always_comb begin
    case (ctrl.resSel)
      RS_ADD:  rawRes = sumX[WORD_W-1:0];
      RS_SUB:  rawRes = diffX[WORD_W-1:0];
      RS_AND:  rawRes = opA & opB;
      RS_OR:   rawRes = opA | opB;
      RS_XOR:  rawRes = opA ^ opB;
      RS_NOT:  rawRes = ~opA;
      RS_MOV:  rawRes = opB;
      default: rawRes = '0;
    endcase
  end

  assign result = rawRes & widthMask;
  assign msbA   = isWord ? opA[WORD_W-1] : opA[BYTE_W-1];
  assign msbB   = isWord ? opB[WORD_W-1] : opB[BYTE_W-1];

endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags
  import flag_alu_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int PAR_W   = 8,
  parameter int NIB_BIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          ctrl,
  input  logic              isWord,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [WORD_W-1:0] result,
  input  logic              carryOut,
  input  logic              msbA,
  input  logic              msbB,
  output aluFlags_t         flagQ
);

  aluFlags_t         flagD;
  logic              msbR;
  logic [WORD_W-1:0] carryVec;
  logic [PAR_W-1:0]  parChain;

  assign msbR     = isWord ? result[WORD_W-1] : result[BYTE_W-1];
  assign carryVec = opA ^ opB ^ result;

  // Even-parity chain over the low bits of the result
  genvar gi;
  generate
    for (gi = 0; gi < PAR_W; gi++) begin : g_par
      if (gi == 0) begin : g_first
        assign parChain[gi] = result[gi];
      end else begin : g_next
        assign parChain[gi] = parChain[gi-1] ^ result[gi];
      end
    end
  endgenerate

  always_comb begin
    flagD     = flagQ;
    flagD.zro = (result == '0);
    flagD.sgn = msbR;
    flagD.par = ~parChain[PAR_W-1];
    case (ctrl.flagKind)
      FK_ARITH_ADD: begin
        flagD.cry = carryOut;
        flagD.aux = carryVec[NIB_BIT];
        flagD.ovf = (msbA == msbB) && (msbR != msbA);
      end
      FK_ARITH_SUB: begin
        flagD.cry = carryOut;
        flagD.aux = carryVec[NIB_BIT];
        flagD.ovf = (msbA != msbB) && (msbR != msbA);
      end
      default: begin
        flagD.cry = 1'b0;
        flagD.aux = 1'b0;
        flagD.ovf = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
    end else if (ctrl.loadFlags) begin
      flagQ <= flagD;
    end
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int OPC_W   = 4,
  parameter int FLAG_W  = 6,
  parameter int NIB_BIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OPC_W-1:0]  opCode,
  input  logic              isWord,
  input  logic [WORD_W-1:0] srcA,
  input  logic [WORD_W-1:0] srcB,
  output logic [WORD_W-1:0] result,
  output logic              destWe,
  output logic [FLAG_W-1:0] flags
);

  aluCtrl_t          ctrl;
  aluFlags_t         flagQ;
  logic              carryOut;
  logic              msbA;
  logic              msbB;
  logic [WORD_W-1:0] opA;
  logic [WORD_W-1:0] opB;

  flag_alu_ctrl #(.OPC_W(OPC_W)) u_ctrl (
    .inValid (inValid),
    .opCode  (opCode),
    .ctrl    (ctrl)
  );

  flag_alu_dp #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_dp (
    .ctrl     (ctrl),
    .isWord   (isWord),
    .srcA     (srcA),
    .srcB     (srcB),
    .result   (result),
    .carryOut (carryOut),
    .msbA     (msbA),
    .msbB     (msbB),
    .opA      (opA),
    .opB      (opB)
  );

  flag_alu_flags #(
    .WORD_W(WORD_W), .BYTE_W(BYTE_W), .PAR_W(BYTE_W), .NIB_BIT(NIB_BIT)
  ) u_flags (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .isWord   (isWord),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .carryOut (carryOut),
    .msbA     (msbA),
    .msbB     (msbB),
    .flagQ    (flagQ)
  );

  assign destWe = ctrl.writeDest;
  assign flags  = flagQ;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [3:0]  opCode,
  input logic        isWord,
  input logic [15:0] srcA,
  input logic [15:0] srcB,
  input logic [15:0] result,
  input logic        destWe,
  input logic [5:0]  flags
);

  logic flagOp;
  logic logicOp;
  assign flagOp  = (opCode <= 4'd6);
  assign logicOp = (opCode >= 4'd3) && (opCode <= 4'd6);

  p_byte_upper_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    !isWord |-> (result[15:8] == 8'h00));

  p_zero_tracks_result_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && flagOp) |=> (flags[3] == ($past(result) == 16'h0000)));

  p_mov_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 4'd8) |=> $stable(flags));

  p_cmp_test_no_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd2 || opCode == 4'd6) |-> !destWe);

  p_logic_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && logicOp) |=> (flags[0] == 1'b0 && flags[2] == 1'b0 && flags[5] == 1'b0));

  p_not_keeps_flags_r11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 4'd7) |=> $stable(flags));

  p_idle_holds_r12: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(flags));

  p_idle_no_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> !destWe);

  p_reset_clear_r12: assert property (@(posedge clk)
    !rstN |=> (flags == 6'd0));

endmodule

bind flag_alu flag_alu_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .opCode  (opCode),
  .isWord  (isWord),
  .srcA    (srcA),
  .srcB    (srcB),
  .result  (result),
  .destWe  (destWe),
  .flags   (flags)
);

// File: tb/sim_flag_alu.sv
`timescale 1ns/1ps
module sim_flag_alu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic        isWord = 1'b0;
  logic [15:0] srcA = '0;
  logic [15:0] srcB = '0;
  logic [15:0] result;
  logic        destWe;
  logic [5:0]  flags;

  int checks = 0;
  int errors = 0;
  logic [5:0] expFlags = 6'd0;

  always #10 clk = ~clk;

  flag_alu u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode), .isWord(isWord),
    .srcA(srcA), .srcB(srcB), .result(result), .destWe(destWe), .flags(flags)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected behaviour written from the requirements
  task automatic model(input logic [3:0] op, input logic w, input logic [15:0] a,
                       input logic [15:0] b, output logic [15:0] res, output logic we,
                       inout logic [5:0] fl);
    logic [15:0] m;
    logic [16:0] wide;
    logic c, sa, sb, sr, arith, sub, upd;
    m = w ? 16'hFFFF : 16'h00FF;
    a = a & m;
    b = b & m;
    c = 1'b0; arith = 1'b0; sub = 1'b0; upd = 1'b1; we = 1'b1;
    case (op)
      4'd0: begin wide = {1'b0, a} + {1'b0, b}; res = wide[15:0] & m; arith = 1'b1;
                  c = w ? wide[16] : wide[8]; end
      4'd1, 4'd2: begin res = (a - b) & m; c = (a < b); arith = 1'b1; sub = 1'b1;
                  we = (op == 4'd1); end
      4'd3: res = a & b;
      4'd4: res = a | b;
      4'd5: res = a ^ b;
      4'd6: begin res = a & b; we = 1'b0; end
      4'd7: begin res = ~a & m; upd = 1'b0; end
      4'd8: begin res = b; upd = 1'b0; end
      default: begin res = 16'h0; we = 1'b0; upd = 1'b0; end
    endcase
    sa = w ? a[15] : a[7];
    sb = w ? b[15] : b[7];
    sr = w ? res[15] : res[7];
    if (upd) begin
      fl[0] = c;
      fl[1] = ~^res[7:0];
      fl[2] = arith ? ((a[4] ^ b[4]) ^ res[4]) : 1'b0;
      fl[3] = (res == 16'h0);
      fl[4] = sr;
      fl[5] = arith ? (sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa))) : 1'b0;
    end
  endtask

  task automatic runOp(input string tag, input logic [3:0] op, input logic w,
                       input logic [15:0] a, input logic [15:0] b);
    logic [15:0] er;
    logic        ew;
    model(op, w, a, b, er, ew, expFlags);
    @(negedge clk);
    opCode = op; isWord = w; srcA = a; srcB = b; inValid = 1'b1;
    #2;
    check({tag, " result"}, result, er);
    check({tag, " destWe"}, {15'd0, destWe}, {15'd0, ew});
    @(posedge clk);
    #2;
    inValid = 1'b0;
    check({tag, " flags"}, {10'd0, flags}, {10'd0, expFlags});
  endtask

  task automatic t_reset;
    check("R12 reset flags", {10'd0, flags}, 16'd0);
    check("R12 reset destWe", {15'd0, destWe}, 16'd0);
  endtask

  task automatic t_add;
    runOp("R2 add byte wrap", 4'd0, 1'b0, 16'h12FF, 16'hAB01);
    check("R2 byte wrap flags literal", {10'd0, flags}, 16'h000F);
    runOp("R2 add word carry", 4'd0, 1'b1, 16'hFFFF, 16'h0002);
    runOp("R1 add byte ignores high", 4'd0, 1'b0, 16'hFF10, 16'hEE20);
  endtask

  task automatic t_sub;
    runOp("R3 sub byte borrow", 4'd1, 1'b0, 16'h0003, 16'h0005);
    runOp("R3 sub word no borrow", 4'd1, 1'b1, 16'h9000, 16'h1000);
    runOp("R3 sub word equal", 4'd1, 1'b1, 16'h4321, 16'h4321);
  endtask

  task automatic t_ovf;
    runOp("R4 add byte ovf", 4'd0, 1'b0, 16'h007F, 16'h0001);
    runOp("R4 add word ovf", 4'd0, 1'b1, 16'h7FFF, 16'h0001);
    check("R4 word ovf literal", {10'd0, flags}, 16'h0036);
    runOp("R4 sub word ovf", 4'd1, 1'b1, 16'h8000, 16'h0001);
    runOp("R4 add byte neg no ovf", 4'd0, 1'b0, 16'h00FF, 16'h00FF);
  endtask

  task automatic t_aux;
    runOp("R5 aux add", 4'd0, 1'b0, 16'h0008, 16'h0008);
    runOp("R5 aux sub", 4'd1, 1'b1, 16'h0010, 16'h0001);
    runOp("R5 no aux", 4'd0, 1'b1, 16'h0101, 16'h0202);
  endtask

  task automatic t_parity;
    runOp("R6 parity word low byte", 4'd0, 1'b1, 16'h0100, 16'h0000);
    check("R6 low-byte parity literal", {10'd0, flags}, 16'h0002);
    runOp("R6 parity odd", 4'd4, 1'b1, 16'h0700, 16'h0001);
    runOp("R7 sign byte", 4'd5, 1'b0, 16'h0080, 16'h0000);
  endtask

  task automatic t_mov;
    runOp("R8 preload", 4'd0, 1'b1, 16'h7FFF, 16'h8001);
    runOp("R8 mov word", 4'd8, 1'b1, 16'h1111, 16'hBEEF);
    runOp("R8 mov byte", 4'd8, 1'b0, 16'h1111, 16'hBEEF);
  endtask

  task automatic t_cmp_test;
    runOp("R9 cmp", 4'd2, 1'b1, 16'h0010, 16'h0020);
    runOp("R9 test", 4'd6, 1'b0, 16'h00F0, 16'h000F);
  endtask

  task automatic t_logic;
    runOp("R10 preload", 4'd1, 1'b0, 16'h0000, 16'h0001);
    runOp("R10 and", 4'd3, 1'b1, 16'hF0F0, 16'h8F0F);
    runOp("R10 or", 4'd4, 1'b0, 16'h0011, 16'h0022);
    runOp("R10 xor zero", 4'd5, 1'b1, 16'hA5A5, 16'hA5A5);
  endtask

  task automatic t_not;
    runOp("R11 preload", 4'd1, 1'b1, 16'h0000, 16'h0001);
    runOp("R11 not word", 4'd7, 1'b1, 16'h00FF, 16'h0000);
    runOp("R11 not byte", 4'd7, 1'b0, 16'h1234, 16'h0000);
  endtask

  task automatic t_idle_reserved;
    runOp("R12 preload", 4'd0, 1'b0, 16'h007F, 16'h0001);
    @(negedge clk);
    opCode = 4'd0; isWord = 1'b1; srcA = 16'h0001; srcB = 16'h0001; inValid = 1'b0;
    #2;
    check("R12 idle destWe", {15'd0, destWe}, 16'd0);
    @(posedge clk);
    #2;
    check("R12 idle flags", {10'd0, flags}, {10'd0, expFlags});
    for (int k = 9; k < 16; k++) begin
      runOp("R12 reserved op", 4'(k), 1'b1, 16'h5555, 16'h3333);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    t_add();
    t_sub();
    t_ovf();
    t_aux();
    t_parity();
    t_mov();
    t_cmp_test();
    t_logic();
    t_not();
    t_idle_reserved();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule